// File: doc/BRIEF.md
# Serial Interface Status Flag Register

This block is the 8-bit status register of a serial communication controller. It holds seven flags and one writable control bit. Five of the flags can be cleared by the CPU: transmit buffer empty, receive buffer full, overrun error, framing error and parity error. Two flags are read-only: transmit end and the received multiprocessor bit. The last bit is the transmit multiprocessor bit, which the CPU can read and write freely. The transmitter and receiver datapaths raise the flags through single-cycle event pulses. The transmit-end and received-multiprocessor bits are sampled every cycle from level status inputs.

The CPU cannot set a clearable flag. It clears one with a handshake. First a read must return the flag as 1, which arms that flag's clear state machine. Then a later write with a 0 in that bit position clears it. When a hardware set event arrives in the same cycle as a CPU clear, the set event wins. That clear attempt also disarms the flag, so software has to read the flag again before it can clear it. A synchronous low-power initialization input does the same as reset: it reloads 0x84 and disarms every flag.

Each clearable flag contains a two-state machine. In state `ARM_IDLE` a CPU write of 0 has no effect. In state `ARM_HELD` a CPU write of 0 clears the flag. The machine changes state as follows:
- `ARM_IDLE` moves to `ARM_HELD` when a read sees the flag at 1 and the flag is not being cleared in that cycle.
- `ARM_HELD` moves to `ARM_IDLE` on a write of 0, whether the flag clears or a set event wins.
- `ARM_HELD` moves to `ARM_IDLE` when a hardware clear lowers the flag.
- Either state moves to `ARM_IDLE` on reset or low-power initialization.

Top module: `ser_flag_reg`

## Requirements
- R1: After reset `reg_q` reads 0x84. The bit order from bit 7 down to bit 0 is: transmit empty, receive full, overrun, framing error, parity error, transmit end, received multiprocessor bit, transmit multiprocessor bit.
- R2: One cycle with `lp_init` high loads 0x84 on the next edge and disarms all flags. A write of 0 that follows, with no new read, clears nothing.
- R3: A CPU write of 1 never sets bits 7 to 3.
- R4: A write of 0 to a clearable flag that has not been read as 1 leaves the flag at 1.
- R5: After a read returns a flag as 1, a write with a 0 in that bit clears only that flag. Armed flags that are written 1 stay set and stay armed.
- R6: `ev_tdr_write` clears bit 7. `ev_tdr_to_tsr` or `ev_tx_disable` sets bit 7.
- R7: A set event in the same cycle as a qualifying clear (CPU or `ev_tdr_write`) leaves the flag at 1. The CPU clear attempt disarms the flag.
- R8: Bit 2 and bit 1 equal `st_tx_end` and `st_rx_mpb` one cycle later. CPU writes do not change them.
- R9: Bit 0 takes `cpu_wdata[0]` on every CPU write.
- R10: Pulses on `ev_rx_done`, `ev_overrun`, `ev_frame_err` and `ev_parity_err` set bits 6, 5, 4 and 3.
- R11: A read that returns a flag as 0 does not arm it. If the flag is set afterwards, a write of 0 without a new read leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_init | input | 1 | Synchronous low-power-mode initialization |
| cpu_rd | input | 1 | CPU read strobe; arms flags that read as 1 |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| ev_tdr_write | input | 1 | Pulse: CPU wrote the transmit data register |
| ev_tdr_to_tsr | input | 1 | Pulse: transmit data moved into the shift register |
| ev_tx_disable | input | 1 | Pulse: transmitter enable cleared |
| ev_rx_done | input | 1 | Pulse: received byte ready |
| ev_overrun | input | 1 | Pulse: overrun detected |
| ev_frame_err | input | 1 | Pulse: framing error detected |
| ev_parity_err | input | 1 | Pulse: parity error detected |
| st_tx_end | input | 1 | Level: transmitter idle after last frame |
| st_rx_mpb | input | 1 | Level: multiprocessor bit of received frame |
| reg_q | output | 8 | Register value, read by the CPU |

## Verification
The clear handshake is tried in these orders:
- A write of 0 with no prior read.
- A read of 1 followed by a write of 0.
- A read of 0, then a set event, then a write of 0.
- A read of 1, then a write of 0 in the same cycle as a set event.

Together these separate a correctly armed clear from an unarmed one and from a lost set event. Mixed write patterns (zeros in some flag bits, ones in others) show whether clearing stays confined to the selected bits. They also show whether a write of 1 leaves the arm in place. The transmit-empty flag is tried with each of its set and clear sources alone and with a set and a clear together. Low-power initialization is applied while flags are armed, to confirm that the arms are dropped.

// File: rtl/ser_flag_pkg.sv
package ser_flag_pkg;

    localparam int unsigned REG_W     = 8;
    localparam logic [REG_W-1:0] INIT_VALUE = 8'h84;

    localparam int unsigned BIT_TXE   = 7;
    localparam int unsigned BIT_RXF   = 6;
    localparam int unsigned BIT_OVR   = 5;
    localparam int unsigned BIT_FRM   = 4;
    localparam int unsigned BIT_PAR   = 3;
    localparam int unsigned BIT_TEND  = 2;
    localparam int unsigned BIT_MPBR  = 1;
    localparam int unsigned BIT_MPBT  = 0;

    localparam int unsigned CLR_LO    = BIT_PAR;
    localparam int unsigned CLR_HI    = BIT_TXE;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_HELD = 1'b1
    } arm_state_e;

endpackage

// File: rtl/ser_flag_cell.sv
module ser_flag_cell
    import ser_flag_pkg::*;
#(
    parameter logic INIT_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic rd_i,
    input  logic wr_zero_i,
    output logic flag_o
);

    arm_state_e state_q, state_d;
    logic       flag_q, flag_d;
    logic       hw_drop;

    assign hw_drop = hw_clr_i && !set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_IDLE;
            flag_q  <= INIT_VAL;
        end else begin
            state_q <= state_d;
            flag_q  <= flag_d;
        end
    end

    // next state and next flag value
    always_comb begin
        state_d = state_q;
        flag_d  = flag_q;
        if (init_i) begin
            state_d = ARM_IDLE;
            flag_d  = INIT_VAL;
        end else begin
            unique case (state_q)
                ARM_IDLE: begin
                    if (rd_i && flag_q && !hw_drop)
                        state_d = ARM_HELD;
                end
                ARM_HELD: begin
                    if (wr_zero_i || hw_drop)
                        state_d = ARM_IDLE;
                end
                default: state_d = ARM_IDLE;
            endcase

            if (set_i)
                flag_d = 1'b1;
            else if (hw_clr_i)
                flag_d = 1'b0;
            else if (wr_zero_i && state_q == ARM_HELD)
                flag_d = 1'b0;
        end
    end

    always_comb begin
        flag_o = flag_q;
    end

endmodule

// File: rtl/ser_flag_track.sv
module ser_flag_track #(
    parameter logic INIT_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic lvl_i,
    output logic bit_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bit_o <= INIT_VAL;
        else if (init_i)
            bit_o <= INIT_VAL;
        else
            bit_o <= lvl_i;
    end

endmodule

// File: rtl/ser_flag_reg.sv
module ser_flag_reg
    import ser_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_init,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    input  logic             ev_tdr_write,
    input  logic             ev_tdr_to_tsr,
    input  logic             ev_tx_disable,
    input  logic             ev_rx_done,
    input  logic             ev_overrun,
    input  logic             ev_frame_err,
    input  logic             ev_parity_err,
    input  logic             st_tx_end,
    input  logic             st_rx_mpb,
    output logic [REG_W-1:0] reg_q
);

    logic [CLR_HI:CLR_LO] set_v;
    logic [CLR_HI:CLR_LO] clr_v;
    logic [CLR_HI:CLR_LO] flag_v;
    logic                 tend_q;
    logic                 mpbr_q;
    logic                 mpbt_q;
    logic                 unused_wbits;

    assign unused_wbits = ^cpu_wdata[BIT_TEND:BIT_MPBR];

    always_comb begin
        set_v          = '0;
        clr_v          = '0;
        set_v[BIT_TXE] = ev_tdr_to_tsr || ev_tx_disable;
        clr_v[BIT_TXE] = ev_tdr_write;
        set_v[BIT_RXF] = ev_rx_done;
        set_v[BIT_OVR] = ev_overrun;
        set_v[BIT_FRM] = ev_frame_err;
        set_v[BIT_PAR] = ev_parity_err;
    end

    for (genvar b = CLR_LO; b <= CLR_HI; b++) begin : g_clr
        ser_flag_cell #(
            .INIT_VAL (INIT_VALUE[b])
        ) i_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .init_i    (lp_init),
            .set_i     (set_v[b]),
            .hw_clr_i  (clr_v[b]),
            .rd_i      (cpu_rd),
            .wr_zero_i (cpu_wr && !cpu_wdata[b]),
            .flag_o    (flag_v[b])
        );
    end

    ser_flag_track #(.INIT_VAL(INIT_VALUE[BIT_TEND])) i_tend (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (lp_init),
        .lvl_i  (st_tx_end),
        .bit_o  (tend_q)
    );

    ser_flag_track #(.INIT_VAL(INIT_VALUE[BIT_MPBR])) i_mpbr (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (lp_init),
        .lvl_i  (st_rx_mpb),
        .bit_o  (mpbr_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mpbt_q <= INIT_VALUE[BIT_MPBT];
        else if (lp_init)
            mpbt_q <= INIT_VALUE[BIT_MPBT];
        else if (cpu_wr)
            mpbt_q <= cpu_wdata[BIT_MPBT];
    end

    always_comb begin
        reg_q                  = '0;
        reg_q[CLR_HI:CLR_LO]   = flag_v;
        reg_q[BIT_TEND]        = tend_q;
        reg_q[BIT_MPBR]        = mpbr_q;
        reg_q[BIT_MPBT]        = mpbt_q;
    end

endmodule

// File: rtl/ser_flag_chk.sv
module ser_flag_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lp_init,
    input logic       cpu_wr,
    input logic [7:0] cpu_wdata,
    input logic       ev_tdr_write,
    input logic       ev_tdr_to_tsr,
    input logic       ev_tx_disable,
    input logic       ev_rx_done,
    input logic       ev_overrun,
    input logic       st_tx_end,
    input logic       st_rx_mpb,
    input logic [7:0] reg_q
);

    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        lp_init |=> reg_q == 8'h84); // R2

    AST_TXE_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_q[7] && !ev_tdr_to_tsr && !ev_tx_disable && !lp_init) |=> !reg_q[7]); // R3

    AST_TXE_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tdr_write && !ev_tdr_to_tsr && !ev_tx_disable && !lp_init) |=> !reg_q[7]); // R6

    AST_TXE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_tdr_to_tsr || ev_tx_disable) && !lp_init) |=> reg_q[7]); // R7

    AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_done && !lp_init) |=> reg_q[6]); // R10

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_overrun && !lp_init) |=> reg_q[5]); // R10

    AST_TEND_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_init |=> reg_q[2] == $past(st_tx_end)); // R8

    AST_MPBR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_init |=> reg_q[1] == $past(st_rx_mpb)); // R8

    AST_MPBT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !lp_init) |=> reg_q[0] == $past(cpu_wdata[0])); // R9

endmodule

bind ser_flag_reg ser_flag_chk i_chk (.*);

// File: tb/test_ser_flag_reg.sv
`timescale 1ns/1ps
module test_ser_flag_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_init = 1'b0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic       ev_tdr_write = 1'b0;
    logic       ev_tdr_to_tsr = 1'b0;
    logic       ev_tx_disable = 1'b0;
    logic       ev_rx_done = 1'b0;
    logic       ev_overrun = 1'b0;
    logic       ev_frame_err = 1'b0;
    logic       ev_parity_err = 1'b0;
    logic       st_tx_end = 1'b1;
    logic       st_rx_mpb = 1'b0;
    logic [7:0] reg_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ser_flag_reg i_ser_flag_reg (.*);

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cpu_read(output logic [7:0] v);
        cpu_rd = 1'b1;
        v = reg_q;
        tick();
        cpu_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic [7:0] d);
        cpu_wr = 1'b1;
        cpu_wdata = d;
        tick();
        cpu_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset value", reg_q, 8'h84);
    endtask

    task automatic t_sw_no_set();
        cpu_write(8'h7B);
        chk("R3 R4 R8 R9 write without read", reg_q, 8'h85);
    endtask

    task automatic t_read_clear();
        logic [7:0] v;
        cpu_read(v);
        chk("R1 read value", v, 8'h85);
        cpu_write(8'h00);
        chk("R5 armed clear of TXE", reg_q, 8'h04);
    endtask

    task automatic t_rx_flags();
        logic [7:0] v;
        ev_rx_done = 1'b1; tick(); ev_rx_done = 1'b0;
        chk("R10 rx done sets bit6", reg_q, 8'h44);
        ev_overrun = 1'b1; tick(); ev_overrun = 1'b0;
        ev_frame_err = 1'b1; tick(); ev_frame_err = 1'b0;
        ev_parity_err = 1'b1; tick(); ev_parity_err = 1'b0;
        chk("R10 error pulses set bits5..3", reg_q, 8'h7C);
        cpu_read(v);
        cpu_write(8'hBF);
        chk("R5 selective clear of bit6, R3 no TXE set", reg_q, 8'h3D);
        cpu_write(8'h01);
        chk("R5 arm kept across write of one", reg_q, 8'h05);
    endtask

    task automatic t_zero_read_no_arm();
        logic [7:0] v;
        cpu_read(v);
        ev_rx_done = 1'b1; tick(); ev_rx_done = 1'b0;
        cpu_write(8'h01);
        chk("R11 read of zero does not arm", reg_q, 8'h45);
        cpu_read(v);
        cpu_write(8'h01);
        chk("R11 re-read then clear", reg_q, 8'h05);
    endtask

    task automatic t_txe_events();
        ev_tdr_to_tsr = 1'b1; tick(); ev_tdr_to_tsr = 1'b0;
        chk("R6 transfer sets TXE", reg_q, 8'h85);
        ev_tdr_write = 1'b1; tick(); ev_tdr_write = 1'b0;
        chk("R6 data write clears TXE", reg_q, 8'h05);
        ev_tx_disable = 1'b1; tick(); ev_tx_disable = 1'b0;
        chk("R6 tx disable sets TXE", reg_q, 8'h85);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        cpu_read(v);
        ev_tdr_to_tsr = 1'b1;
        cpu_write(8'h01);
        ev_tdr_to_tsr = 1'b0;
        chk("R7 set beats CPU clear", reg_q, 8'h85);
        cpu_write(8'h01);
        chk("R7 arm dropped after collision", reg_q, 8'h85);
        ev_tdr_write = 1'b1; ev_tx_disable = 1'b1; tick();
        ev_tdr_write = 1'b0; ev_tx_disable = 1'b0;
        chk("R7 set beats data write clear", reg_q, 8'h85);
    endtask

    task automatic t_status_bits();
        st_tx_end = 1'b0; st_rx_mpb = 1'b1; tick();
        chk("R8 status levels followed", reg_q, 8'h83);
        cpu_write(8'h05);
        chk("R8 read-only bits ignore write", reg_q, 8'h83);
        st_tx_end = 1'b1; st_rx_mpb = 1'b0; tick();
        chk("R8 status levels restored", reg_q, 8'h85);
    endtask

    task automatic t_lowpower();
        logic [7:0] v;
        ev_rx_done = 1'b1; tick(); ev_rx_done = 1'b0;
        cpu_read(v);
        chk("R1 read before init", v, 8'hC5);
        lp_init = 1'b1; tick(); lp_init = 1'b0;
        chk("R2 init reloads value", reg_q, 8'h84);
        cpu_write(8'h00);
        chk("R2 init disarms flags", reg_q, 8'h84);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sw_no_set();
        t_read_clear();
        t_rx_flags();
        t_zero_read_no_arm();
        t_txe_events();
        t_set_wins();
        t_status_bits();
        t_lowpower();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule